// File: doc/BRIEF.md
# Power-Estimation Arm Sequencer

This block is a small register-bus master that brings the power-estimation hardware into its operating configuration. After a single start pulse it performs six bus transactions in a fixed order: two writes into the estimation control page, a read-modify-write that sets bit 0 of an enable register, and two writes into a trailing control page. The sequence has no loop and no ramp. A second run leaves the target registers exactly as the first run left them.

Two enable inputs control the run. Both are sampled when the start pulse is accepted. The estimation enable decides whether any traffic happens at all. The tracking enable selects the value that the second write carries. The master side is a valid/ready bus with address, write data, write enable and read data. A busy level covers the whole run, and a one-cycle done pulse closes it.

Top module: `pas_arm_seq`

## Requirements
- R1: A start pulse seen while busy is low is accepted, and busy is high from the next cycle until the cycle in which done is high.
- R2: When the estimation enable is 0 at acceptance, no bus access is issued and done pulses two cycles after the start cycle.
- R3: When the estimation enable is 1, the first access writes 0x11 to BASE_ADDR. The second writes to BASE_ADDR+0x4, with data 1 if the tracking enable was 1 at acceptance and 0 otherwise.
- R4: The third access is a read (write enable 0) of BASE_ADDR+0x4000. The fourth writes the returned word with bit 0 set back to that same address.
- R5: The fifth access writes 0x3fff to TRAIL_ADDR, and the sixth writes 0xf to TRAIL_ADDR+0x1b0. No other access follows.
- R6: An access keeps valid high, with address, data and write enable unchanged, until ready is sampled high. The next access is only presented after that handshake.
- R7: Done is high for exactly one cycle, the cycle after the last handshake, and busy is low in that cycle.
- R8: Start pulses that arrive while busy are ignored. They add no access and do not extend the run.
- R9: Running the sequence again against the register state left by a previous run issues the same writes with the same values.
- R10: After reset, busy, done and valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| est_en_i | input | 1 | Estimation enable, sampled at acceptance |
| trk_en_i | input | 1 | Tracking enable, selects the second write value |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| bus_valid_o | output | 1 | Access request valid |
| bus_addr_o | output | ADDR_W | Access address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_ready_i | input | 1 | Target accepts the access at this edge |
| bus_rdata_i | input | DATA_W | Read data, valid with ready on a read |

## Verification
Busy is due one cycle after the accepted start. In the disabled case, done is due one cycle after that. In a full run, each new access is presented in the cycle that follows the previous handshake, and done appears one cycle after the sixth handshake. The bench drives inputs and samples outputs on the falling edge, so every check reads the value that the preceding rising edge registered. The bus model also varies the ready delay between zero and several cycles, which places the handshakes at different distances from start.

// File: rtl/pas_pkg.sv
package pas_pkg;
  localparam int NUM_OPS = 6;
  localparam int IDX_W   = $clog2(NUM_OPS);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SKIP = 2'd2
  } pas_state_e;

  typedef enum logic [2:0] {
    K_WR_CONST = 3'd0,
    K_WR_FLAG  = 3'd1,
    K_RD       = 3'd2,
    K_WR_RMW   = 3'd3
  } pas_kind_e;

  function automatic pas_kind_e op_kind(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd1:    op_kind = K_WR_FLAG;
      3'd2:    op_kind = K_RD;
      3'd3:    op_kind = K_WR_RMW;
      default: op_kind = K_WR_CONST;
    endcase
  endfunction
endpackage

// File: rtl/pas_step_table.sv
module pas_step_table
  import pas_pkg::*;
#(
  parameter int              ADDR_W       = 36,
  parameter int              DATA_W       = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 36'h2_6b8f_0000,
  parameter logic [ADDR_W-1:0] TRAIL_ADDR = 36'h2_6b8e_c42c,
  parameter logic [ADDR_W-1:0] CTL_OFS    = 36'h4,
  parameter logic [ADDR_W-1:0] LEE_OFS    = 36'h4000,
  parameter logic [ADDR_W-1:0] TRAIL_STEP = 36'h1b0,
  parameter logic [DATA_W-1:0] PPT_WORD   = 32'h11,
  parameter logic [DATA_W-1:0] TRAIL_W0   = 32'h3fff,
  parameter logic [DATA_W-1:0] TRAIL_W1   = 32'hf
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              trk_i,
  input  logic [DATA_W-1:0] rd_val_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] A_CTL = BASE_ADDR + CTL_OFS;
  localparam logic [ADDR_W-1:0] A_LEE = BASE_ADDR + LEE_OFS;
  localparam logic [ADDR_W-1:0] A_TR1 = TRAIL_ADDR + TRAIL_STEP;
  localparam logic [DATA_W-1:0] BIT0  = {{(DATA_W-1){1'b0}}, 1'b1};

  pas_kind_e kind;
  assign kind = op_kind(idx_i);

  always_comb begin
    addr_o  = BASE_ADDR;
    wdata_o = '0;
    we_o    = 1'b1;
    last_o  = (idx_i == IDX_W'(NUM_OPS - 1));
    case (kind)
      K_WR_FLAG: begin
        addr_o  = A_CTL;
        wdata_o = trk_i ? BIT0 : '0;
      end
      K_RD: begin
        addr_o = A_LEE;
        we_o   = 1'b0;
      end
      K_WR_RMW: begin
        addr_o  = A_LEE;
        wdata_o = rd_val_i | BIT0;
      end
      default: begin
        case (idx_i)
          3'd4: begin addr_o = TRAIL_ADDR; wdata_o = TRAIL_W0; end
          3'd5: begin addr_o = A_TR1;      wdata_o = TRAIL_W1; end
          default: begin addr_o = BASE_ADDR; wdata_o = PPT_WORD; end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/pas_ctrl.sv
module pas_ctrl
  import pas_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              est_en_i,
  input  logic              trk_en_i,
  input  logic              bus_ready_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [IDX_W-1:0]  nxt_idx_o,
  output logic              nxt_trk_o,
  output logic [DATA_W-1:0] nxt_rd_o,
  input  logic [ADDR_W-1:0] tbl_addr_i,
  input  logic [DATA_W-1:0] tbl_wdata_i,
  input  logic              tbl_we_i,
  input  logic              tbl_last_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o
);
  pas_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              trk_q;
  logic [DATA_W-1:0] rd_q;
  logic              last_q;
  logic              hs;

  assign hs = valid_o && bus_ready_i;

  always_comb begin
    nxt_idx_o = idx_q;
    nxt_trk_o = trk_q;
    nxt_rd_o  = rd_q;
    if (state_q == ST_IDLE) begin
      nxt_idx_o = '0;
      nxt_trk_o = trk_en_i;
    end else if (state_q == ST_RUN && hs) begin
      nxt_idx_o = idx_q + IDX_W'(1);
      if (!we_o) nxt_rd_o = bus_rdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      trk_q   <= 1'b0;
      rd_q    <= '0;
      last_q  <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      valid_o <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      we_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            busy_o <= 1'b1;
            idx_q  <= nxt_idx_o;
            trk_q  <= nxt_trk_o;
            if (est_en_i) begin
              state_q <= ST_RUN;
              valid_o <= 1'b1;
              addr_o  <= tbl_addr_i;
              wdata_o <= tbl_wdata_i;
              we_o    <= tbl_we_i;
              last_q  <= tbl_last_i;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_SKIP: begin
          state_q <= ST_IDLE;
          busy_o  <= 1'b0;
          done_o  <= 1'b1;
        end
        ST_RUN: begin
          if (hs) begin
            idx_q <= nxt_idx_o;
            rd_q  <= nxt_rd_o;
            if (last_q) begin
              state_q <= ST_IDLE;
              valid_o <= 1'b0;
              we_o    <= 1'b0;
              busy_o  <= 1'b0;
              done_o  <= 1'b1;
            end else begin
              addr_o  <= tbl_addr_i;
              wdata_o <= tbl_wdata_i;
              we_o    <= tbl_we_i;
              last_q  <= tbl_last_i;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pas_arm_seq.sv
module pas_arm_seq
  import pas_pkg::*;
#(
  parameter int              ADDR_W     = 36,
  parameter int              DATA_W     = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 36'h2_6b8f_0000,
  parameter logic [ADDR_W-1:0] TRAIL_ADDR = 36'h2_6b8e_c42c
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              est_en_i,
  input  logic              trk_en_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              bus_valid_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_we_o,
  input  logic              bus_ready_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  logic [IDX_W-1:0]  nxt_idx;
  logic              nxt_trk;
  logic [DATA_W-1:0] nxt_rd;
  logic [ADDR_W-1:0] tbl_addr;
  logic [DATA_W-1:0] tbl_wdata;
  logic              tbl_we;
  logic              tbl_last;

  pas_step_table #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .BASE_ADDR(BASE_ADDR), .TRAIL_ADDR(TRAIL_ADDR)
  ) u_tbl (
    .idx_i(nxt_idx), .trk_i(nxt_trk), .rd_val_i(nxt_rd),
    .addr_o(tbl_addr), .wdata_o(tbl_wdata), .we_o(tbl_we), .last_o(tbl_last)
  );

  pas_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .start_i(start_i), .est_en_i(est_en_i), .trk_en_i(trk_en_i),
    .bus_ready_i(bus_ready_i), .bus_rdata_i(bus_rdata_i),
    .nxt_idx_o(nxt_idx), .nxt_trk_o(nxt_trk), .nxt_rd_o(nxt_rd),
    .tbl_addr_i(tbl_addr), .tbl_wdata_i(tbl_wdata),
    .tbl_we_i(tbl_we), .tbl_last_i(tbl_last),
    .busy_o(busy_o), .done_o(done_o), .valid_o(bus_valid_o),
    .addr_o(bus_addr_o), .wdata_o(bus_wdata_o), .we_o(bus_we_o)
  );
endmodule

// File: rtl/pas_arm_chk.sv
module pas_arm_chk #(
  parameter int              ADDR_W     = 36,
  parameter int              DATA_W     = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 36'h2_6b8f_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              est_en_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              bus_valid_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_we_o,
  input logic              bus_ready_i
);
  logic [3:0] hs_cnt;
  logic       est_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_cnt <= '0;
      est_q  <= 1'b0;
    end else if (start_i && !busy_o) begin
      hs_cnt <= '0;
      est_q  <= est_en_i;
    end else if (bus_valid_o && bus_ready_i) begin
      hs_cnt <= hs_cnt + 4'd1;
    end
  end

  p_reset_quiet_r10: assert property (@(posedge clk)
    $past(rst) && !rst |-> !busy_o && !done_o && !bus_valid_o);
  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (rst)
    start_i && !busy_o |=> busy_o);
  p_access_count_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> hs_cnt == (est_q ? 4'd6 : 4'd0));
  p_first_write_r3: assert property (@(posedge clk) disable iff (rst)
    bus_valid_o && hs_cnt == 4'd0 |-> bus_we_o && bus_addr_o == BASE_ADDR && bus_wdata_o == 32'h11);
  p_read_we_low_r4: assert property (@(posedge clk) disable iff (rst)
    bus_valid_o && hs_cnt == 4'd2 |-> !bus_we_o && bus_addr_o == BASE_ADDR + 36'h4000);
  p_rmw_bit0_r4: assert property (@(posedge clk) disable iff (rst)
    bus_valid_o && hs_cnt == 4'd3 |-> bus_we_o && bus_wdata_o[0]);
  p_hold_until_ready_r6: assert property (@(posedge clk) disable iff (rst)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o)
      && $stable(bus_wdata_o) && $stable(bus_we_o));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o ##1 !done_o);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !bus_valid_o);
endmodule

bind pas_arm_seq pas_arm_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .est_en_i(est_en_i),
  .busy_o(busy_o), .done_o(done_o), .bus_valid_o(bus_valid_o),
  .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_we_o(bus_we_o),
  .bus_ready_i(bus_ready_i)
);

// File: tb/tb_pas_arm_seq.sv
module tb_pas_arm_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [35:0] BASE  = 36'h2_6b8f_0000;
  localparam logic [35:0] TRAIL = 36'h2_6b8e_c42c;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, est_en_i = 1'b0, trk_en_i = 1'b0;
  logic busy_o, done_o, bus_valid_o, bus_we_o;
  logic [35:0] bus_addr_o;
  logic [31:0] bus_wdata_o;
  logic bus_ready_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pas_arm_seq dut (
    .clk(clk), .rst(rst), .start_i(start_i), .est_en_i(est_en_i),
    .trk_en_i(trk_en_i), .busy_o(busy_o), .done_o(done_o),
    .bus_valid_o(bus_valid_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_we_o(bus_we_o),
    .bus_ready_i(bus_ready_i), .bus_rdata_i(bus_rdata_i)
  );

  typedef struct { logic [35:0] a; logic w; logic [31:0] d; string tag; } acc_t;
  acc_t exp_q[$];

  int checks = 0, errors = 0;
  int ready_dly = 0;
  int wcnt = 0;
  logic [31:0] lee_reg = 32'h0000_00a0;
  logic prev_stall = 1'b0;
  logic [35:0] prev_addr = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic push_seq(input logic trk);
    exp_q.push_back('{BASE, 1'b1, 32'h11, "R3"});
    exp_q.push_back('{BASE + 36'h4, 1'b1, trk ? 32'h1 : 32'h0, "R3"});
    exp_q.push_back('{BASE + 36'h4000, 1'b0, 32'h0, "R4"});
    exp_q.push_back('{BASE + 36'h4000, 1'b1, lee_reg | 32'h1, "R4"});
    exp_q.push_back('{TRAIL, 1'b1, 32'h3fff, "R5"});
    exp_q.push_back('{TRAIL + 36'h1b0, 1'b1, 32'hf, "R5"});
  endtask

  // bus target model and scoreboard monitor
  always @(negedge clk) begin
    if (prev_stall) begin
      chk("R6 valid held", {63'd0, bus_valid_o}, 64'd1);
      chk("R6 addr held", {28'd0, bus_addr_o}, {28'd0, prev_addr});
    end
    if (bus_valid_o && !rst) begin
      bus_ready_i = (wcnt >= ready_dly);
      wcnt = bus_ready_i ? 0 : wcnt + 1;
      bus_rdata_i = lee_reg;
      if (bus_ready_i) begin
        if (exp_q.size() == 0) begin
          chk("R8 unexpected access", {28'd0, bus_addr_o}, 64'd0);
          checks--; errors++;
          $display("FAIL R2/R8: extra access addr %0h expected none", bus_addr_o);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          chk({e.tag, " addr"}, {28'd0, bus_addr_o}, {28'd0, e.a});
          chk({e.tag, " we"}, {63'd0, bus_we_o}, {63'd0, e.w});
          if (e.w) chk({e.tag, " data"}, {32'd0, bus_wdata_o}, {32'd0, e.d});
        end
        if (bus_we_o && bus_addr_o == BASE + 36'h4000) lee_reg = bus_wdata_o;
      end
    end else begin
      bus_ready_i = 1'b0;
      wcnt = 0;
    end
    prev_stall = bus_valid_o && !bus_ready_i && !rst;
    prev_addr  = bus_addr_o;
  end

  task automatic run(input logic est, input logic trk, input int dly, input logic glitch);
    int n;
    ready_dly = dly;
    if (est) push_seq(trk);
    @(negedge clk);
    start_i = 1'b1; est_en_i = est; trk_en_i = trk;
    @(negedge clk);
    start_i = 1'b0; est_en_i = 1'b0; trk_en_i = ~trk;
    chk("R1 busy after start", {63'd0, busy_o}, 64'd1);
    n = 1;
    while (!done_o && n < 500) begin
      if (glitch && n == 3) begin
        start_i = 1'b1; est_en_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    if (!est) chk("R2 done latency", n, 2);
    chk("R7 done seen", {63'd0, done_o}, 64'd1);
    chk("R7 busy low at done", {63'd0, busy_o}, 64'd0);
    chk("R5 all accesses issued", exp_q.size(), 0);
    @(negedge clk);
    chk("R7 done single cycle", {63'd0, done_o}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 busy reset", {63'd0, busy_o}, 64'd0);
    chk("R10 done reset", {63'd0, done_o}, 64'd0);
    chk("R10 valid reset", {63'd0, bus_valid_o}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    run(1'b1, 1'b1, 0, 1'b0);
    chk("R4 register bit0 set", {32'd0, lee_reg}, 64'ha1);
    run(1'b1, 1'b1, 2, 1'b0);   // R9 rerun: same writes, same final value
    chk("R9 register unchanged", {32'd0, lee_reg}, 64'ha1);
    lee_reg = 32'h5000_0000;
    run(1'b1, 1'b0, 3, 1'b0);
    chk("R4 rmw keeps other bits", {32'd0, lee_reg}, 64'h5000_0001);
    run(1'b0, 1'b1, 0, 1'b0);   // R2 skip
    run(1'b1, 1'b0, 1, 1'b1);   // R8 start while busy
    repeat (6) @(negedge clk);
    chk("R8 no rerun after ignored start", {63'd0, busy_o}, 64'd0);
    chk("R8 no stray access", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule